// File: doc/BRIEF.md
# Coarse/Fine Up-Counter Frequency Divider

This block divides a fast input clock by a programmable ratio M = N·CR + 2·FR, where N is a fixed prescale factor, CR is a coarse count and FR is a fine count. There are no loadable down-counters. A single up-counter runs from zero and is cleared each time an equality detector reports that it has reached the count for the current phase.

In the coarse phase the counter advances once every N input cycles until it equals CR. In the fine phase it advances once every two input cycles until it equals FR. A phase sequencer chooses the active prescale path and the compare target, and it pulses the counter clear for one cycle at the end of each phase. When the fine phase ends, the block emits a one-cycle output pulse. The prescaler and the path selection are modelled as digital clock enables in the input clock domain.

Top module: `updiv_seq`

## Requirements
- R1: While `rst_n` is low, `div_pulse` is 0 and all state is cleared asynchronously. On the first rising edge with `rst_n` high, the block captures `cr_in` and `fr_in` and starts a period. That edge produces no pulse.
- R2: Let E be an edge on which the operands are captured. `div_pulse` goes high for exactly one cycle after edge E+M, with M = PRE_DIV·CR + 2·FR. That same edge captures the operands again, so the pulses repeat every M cycles.
- R3: The up-counter, the prescaler and the divide-by-2 stage are all zero in the cycle after the equality detector fires. Each phase therefore starts counting from zero, after a clear that lasts one cycle.
- R4: The coarse phase lasts exactly PRE_DIV·CR input cycles. With CR=1 and FR=0 the period is PRE_DIV, which is the shortest period.
- R5: When the captured FR is 0, the fine phase is skipped and the period is PRE_DIV·CR.
- R6: A captured CR of 0 is treated as 1.
- R7: Changes on `cr_in` or `fr_in` between capture edges have no effect on the period in progress. Only the values present on the capture edge count.
- R8: The largest operands, CR = FR = 2^CNT_W−1, give the full period PRE_DIV·CR + 2·FR with no counter wrap.
- R9: Asserting `rst_n` in the middle of a period aborts it at once. After release, operation restarts as described in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cr_in | input | CNT_W | Coarse count |
| fr_in | input | CNT_W | Fine count |
| div_pulse | output | 1 | One-cycle pulse once per M input cycles |

## Verification
The bench builds the block with PRE_DIV=5 and CNT_W=4. An odd prescale factor exposes off-by-one errors at the prescaler wrap. The 4-bit counter lets the largest operands (15, 15) fit in a 105-cycle period, so the counter ceiling is exercised within a short run. The same settings keep each scenario to a few hundred cycles, leaving room to change operands mid-period, to run the zero-operand cases and to apply a reset in the middle of a period.

// File: rtl/updiv_seq.sv
module updiv_seq #(
  parameter int PRE_DIV = 32,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cr_in,
  input  logic [CNT_W-1:0] fr_in,
  output logic             div_pulse
);

  localparam int PW = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);

  typedef enum logic [1:0] {PH_LOAD, PH_COARSE, PH_FINE} phase_t;

  phase_t            phase;
  logic [PW-1:0]     pre;
  logic              half;
  logic [CNT_W-1:0]  cnt, cr_q, fr_q, target;
  logic              tick, hit, per_end, capture;

  assign tick    = (phase == PH_COARSE) ? (pre == PRE_LAST)
                 : (phase == PH_FINE)   ? half : 1'b0;
  assign target  = (phase == PH_FINE) ? fr_q : cr_q;
  assign hit     = tick && ((cnt + 1'b1) == target);
  assign per_end = hit && ((phase == PH_FINE) || (fr_q == '0));
  assign capture = (phase == PH_LOAD) || per_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_LOAD;
      pre       <= '0;
      half      <= 1'b0;
      cnt       <= '0;
      cr_q      <= '0;
      fr_q      <= '0;
      div_pulse <= 1'b0;
    end else begin
      div_pulse <= per_end;
      if (capture) begin
        cr_q <= (cr_in == '0) ? CNT_W'(1) : cr_in;
        fr_q <= fr_in;
      end
      if (hit)       cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
      if (phase == PH_COARSE && !hit) pre <= (pre == PRE_LAST) ? '0 : pre + 1'b1;
      else                            pre <= '0;
      half <= (phase == PH_FINE && !hit) ? ~half : 1'b0;
      unique case (phase)
        PH_LOAD:   phase <= PH_COARSE;
        PH_COARSE: if (hit && fr_q != '0) phase <= PH_FINE;
        PH_FINE:   if (hit) phase <= PH_COARSE;
        default:   phase <= PH_LOAD;
      endcase
    end
  end

  a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt == '0 && pre == '0 && !half));

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_LOAD) |-> (cnt < target));

  a_r5_fine_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_COARSE && hit && fr_q == '0) |=> (phase == PH_COARSE && div_pulse));

  a_r6_cr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_LOAD) |-> (cr_q != '0));

  a_r7_hold_operands: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_LOAD && !per_end) |=> ($stable(cr_q) && $stable(fr_q)));

  a_r4_presc_range: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_COARSE) |-> (pre <= PRE_LAST));

endmodule

// File: tb/test_updiv_seq.sv
module test_updiv_seq;
  localparam int N  = 5;
  localparam int W  = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cr = '0, fr = '0;
  logic         div_pulse;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done = 0;

  updiv_seq #(.PRE_DIV(N), .CNT_W(W)) i_updiv_seq (
    .clk(clk), .rst_n(rst_n), .cr_in(cr), .fr_in(fr), .div_pulse(div_pulse));

  always #10 clk = ~clk;

  function automatic int mval(input int c, input int f);
    return N * ((c == 0) ? 1 : c) + 2 * f;
  endfunction

  int rem = 0;
  bit started = 0;
  bit exp_p = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      started = 0; exp_p = 0;
    end else if (!started) begin
      started = 1; rem = mval(cr, fr); exp_p = 0;
    end else begin
      rem--;
      if (rem == 0) begin exp_p = 1; rem = mval(cr, fr); end
      else exp_p = 0;
    end
    #1;
    if (!done) begin
      n_chk++;
      if (div_pulse !== exp_p) begin
        n_fail++;
        $display("FAIL %s: div_pulse=%0b expected=%0b at %0t", cur_req, div_pulse, exp_p, $time);
      end
    end
  end

  task automatic run(input int cyc);
    repeat (cyc) @(negedge clk);
  endtask

  task automatic set_ops(input int c, input int f);
    @(negedge clk);
    cr = W'(c); fr = W'(f);
  endtask

  initial begin
    cur_req = "R1";
    cr = 3; fr = 2;
    run(4);
    rst_n = 1'b1;
    cur_req = "R2";
    run(3 * mval(3, 2) + 3);
    cur_req = "R5";
    set_ops(4, 0);
    run(3 * mval(4, 0) + 20);
    cur_req = "R4";
    set_ops(1, 0);
    run(6 * N + 30);
    cur_req = "R6";
    set_ops(0, 1);
    run(4 * mval(0, 1) + 30);
    cur_req = "R8";
    set_ops(15, 15);
    run(3 * mval(15, 15) + 120);
    cur_req = "R7";
    for (int k = 0; k < 60; k++) begin
      set_ops((k * 7 + 2) % 16, (k * 5 + 1) % 16);
      run(6 + (k % 5));
    end
    cur_req = "R9";
    set_ops(2, 3);
    run(40);
    @(negedge clk); rst_n = 1'b0;
    run(3);
    rst_n = 1'b1;
    run(3 * mval(2, 3) + 5);
    cur_req = "R2";
    set_ops(6, 7);
    run(3 * mval(6, 7) + 10);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog %s: run did not finish, actual=hung expected=done", cur_req);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule